// File: doc/BRIEF.md
# Interlocked Handshake Capture Controller

This block accepts parallel words from an external source that paces itself with a two-wire interlocked handshake. The controller offers a transfer on its event line whenever the downstream sample FIFO can take a word. The source answers by asserting a trigger line, and the word on the data bus is taken at that assertion. The controller then withdraws the offer and waits for the trigger to be released. When the release is seen, it writes the word into the FIFO with a one-cycle strobe. After that a programmable idle gap runs before the next offer is made.

The trigger input is asynchronous and passes through a two-stage synchronizer. The data bus is delayed by one register so that the captured word lines up with the synchronized trigger edge. The active level of the trigger and the active level of the event line can each be chosen at run time. A synchronous enable pulls the controller back to the idle wait for FIFO space. It drops the event line and abandons any transfer still in progress. One gap step is one clock cycle, which is 20 ns at 50 MHz. The gap value is 16 bits wide, and zero means no gap.

Top module: `ilock_acq_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released with `en` low, `wr_en` is 0 and `evt_out` sits at its inactive level, which is the inverse of `evt_pol`.
- R2: The offer (event at its active level) is made only while `fifo_space` is 1. It appears one cycle after `fifo_space` rises in the idle state. It is withdrawn one cycle after `fifo_space` falls while no trigger assertion is pending.
- R3: `trig_pol` = 1 makes a high level on `trig_in` the asserted trigger, and `trig_pol` = 0 makes a low level the asserted trigger. Polarity is changed only while `en` is 0.
- R4: `evt_pol` = 1 makes the event line active high, and `evt_pol` = 0 makes it active low.
- R5: The word on `data_in`, held stable from before the trigger asserts until the offer is withdrawn, appears on `wr_data` in the cycle that `wr_en` is 1. This happens after the trigger is released.
- R6: Each completed handshake produces exactly one `wr_en` pulse, one cycle long.
- R7: With `fifo_space` held at 1, the offer reappears exactly `gap_cycles`+1 cycles after the `wr_en` pulse. A value of 0 skips the gap state, and any 16-bit value is honoured.
- R8: Once the trigger assertion has been detected, the offer is withdrawn and stays withdrawn until the trigger is released.
- R9: `en` = 0 withdraws the offer on the next cycle. It discards a transfer whose trigger was asserted but not yet released, so no `wr_en` pulse follows.
- R10: A detected trigger assertion wins over a `fifo_space` fall in the same cycle. The word is still captured and written, and no new offer is made until space returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous enable; 0 forces the idle wait |
| trig_pol | input | 1 | Trigger active level (1 = high) |
| evt_pol | input | 1 | Event active level (1 = high) |
| gap_cycles | input | 16 | Idle cycles after each FIFO write |
| trig_in | input | 1 | Asynchronous handshake trigger from the source |
| data_in | input | 32 | Parallel data bus from the source |
| fifo_space | input | 1 | Sample FIFO can take a word |
| evt_out | output | 1 | Handshake event (transfer offered) |
| wr_en | output | 1 | One-cycle FIFO write strobe |
| wr_data | output | 32 | Word written to the FIFO |

## Verification
A trigger assertion edge and the loss of FIFO space can reach the sequencer in the same cycle. The bench provokes this by counting the two synchronizer stages from the trigger change. It then lowers `fifo_space` on exactly the cycle in which the synchronized edge arrives. It judges the result by requiring the captured word to be written after the trigger is released, and by requiring that no new offer appears while space stays low. A second collision, enable falling while a transfer waits for trigger release, must produce no write at all.

// File: rtl/ilock_acq_pkg.sv
package ilock_acq_pkg;

  typedef enum logic [1:0] {
    ST_SPACE = 2'd0,  // idle, waiting for room in the FIFO
    ST_ARM   = 2'd1,  // offer made, waiting for trigger assertion
    ST_HOLD  = 2'd2,  // word taken, waiting for trigger release
    ST_GAP   = 2'd3   // post-transfer idle gap
  } acq_state_t;

endpackage

// File: rtl/ilock_trig_sync.sv
module ilock_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_raw,
  input  logic pol,
  output logic trig_act,
  output logic trig_rise
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          act_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= trig_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[LAST-1:0], trig_raw};
      end
    end
  endgenerate

  assign trig_act = pol ? sync_q[LAST] : ~sync_q[LAST];

  // reset to "active" so the settling of the chain after reset is never a rise
  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b1;
    else     act_q <= trig_act;
  end

  assign trig_rise = trig_act & ~act_q;

endmodule

// File: rtl/ilock_word_stage.sv
module ilock_word_stage #(
  parameter int DATA_W = 32,
  parameter int LAG    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic              capture,
  input  logic              push,
  output logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = (LAG < 1) ? 1 : LAG;

  logic [DATA_W-1:0] lag_q [DEPTH];
  logic [DATA_W-1:0] cap_q;

  // delay line matching the trigger synchronizer latency
  always_ff @(posedge clk) begin
    lag_q[0] <= data_in;
    for (int i = 1; i < DEPTH; i++) lag_q[i] <= lag_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      wr_data <= '0;
    end else begin
      if (capture) cap_q   <= lag_q[DEPTH-1];
      if (push)    wr_data <= cap_q;
    end
  end

endmodule

// File: rtl/ilock_gap_timer.sv
module ilock_gap_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [DLY_W-1:0] cfg,
  output logic             done
);

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= '0;
    else if (load)         cnt_q <= cfg - DLY_W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - DLY_W'(1);
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/ilock_seq.sv
module ilock_seq
  import ilock_acq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic evt_pol,
  input  logic fifo_space,
  input  logic trig_act,
  input  logic trig_rise,
  input  logic gap_zero,
  input  logic gap_done,
  output logic capture,
  output logic push,
  output logic gap_load,
  output logic evt_act,
  output logic evt_line,
  output logic push_q
);

  acq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SPACE: if (fifo_space) st_d = ST_ARM;
      ST_ARM: begin
        if (trig_rise)        st_d = ST_HOLD;
        else if (!fifo_space) st_d = ST_SPACE;
      end
      ST_HOLD:  if (!trig_act) st_d = gap_zero ? ST_SPACE : ST_GAP;
      ST_GAP:   if (gap_done)  st_d = ST_SPACE;
      default:  st_d = ST_SPACE;
    endcase
    if (!en) st_d = ST_SPACE;
  end

  assign capture  = en && (st_q == ST_ARM)  && trig_rise;
  assign push     = en && (st_q == ST_HOLD) && !trig_act;
  assign gap_load = push && !gap_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_SPACE;
      evt_act  <= 1'b0;
      evt_line <= ~evt_pol;
      push_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      evt_act  <= (st_d == ST_ARM);
      evt_line <= (st_d == ST_ARM) ~^ evt_pol;
      push_q   <= push;
    end
  end

endmodule

// File: rtl/ilock_acq_ctrl.sv
module ilock_acq_ctrl #(
  parameter int DATA_W      = 32,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              trig_pol,
  input  logic              evt_pol,
  input  logic [DLY_W-1:0]  gap_cycles,
  input  logic              trig_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              fifo_space,
  output logic              evt_out,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);

  localparam int DATA_LAG = SYNC_STAGES - 1;

  logic trig_act, trig_rise;
  logic capture, push, gap_load, gap_done;
  logic evt_act;
  logic gap_zero;

  assign gap_zero = (gap_cycles == '0);

  ilock_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .trig_raw  (trig_in),
    .pol       (trig_pol),
    .trig_act  (trig_act),
    .trig_rise (trig_rise)
  );

  ilock_word_stage #(.DATA_W(DATA_W), .LAG(DATA_LAG)) u_word (
    .clk     (clk),
    .rst     (rst),
    .data_in (data_in),
    .capture (capture),
    .push    (push),
    .wr_data (wr_data)
  );

  ilock_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .clr  (!en),
    .load (gap_load),
    .cfg  (gap_cycles),
    .done (gap_done)
  );

  ilock_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .evt_pol    (evt_pol),
    .fifo_space (fifo_space),
    .trig_act   (trig_act),
    .trig_rise  (trig_rise),
    .gap_zero   (gap_zero),
    .gap_done   (gap_done),
    .capture    (capture),
    .push       (push),
    .gap_load   (gap_load),
    .evt_act    (evt_act),
    .evt_line   (evt_out),
    .push_q     (wr_en)
  );

endmodule

// File: rtl/ilock_acq_checker.sv
module ilock_acq_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic fifo_space,
  input logic evt_act,
  input logic wr_en
);

  // R2: an offer stands only on space seen at the previous edge
  assert_offer_needs_space_R2: assert property (@(posedge clk) disable iff (rst)
    evt_act |-> $past(fifo_space));

  // R6: write strobe never lasts two cycles
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R7: no fresh offer in the cycle of the write
  assert_no_offer_on_push_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !evt_act);

  // R9: disabled controller neither offers nor writes
  assert_disable_idles_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!evt_act && !wr_en));

  // R9: a write always follows an enabled cycle
  assert_push_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(en));

endmodule

bind ilock_acq_ctrl ilock_acq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .fifo_space (fifo_space),
  .evt_act    (evt_act),
  .wr_en      (wr_en)
);

// File: tb/sim_ilock_acq_ctrl.sv
`timescale 1ns/1ps
module sim_ilock_acq_ctrl;

  logic        clk = 1'b0;
  logic        rst, en, trig_pol, evt_pol, trig_in, fifo_space;
  logic [15:0] gap_cycles;
  logic [31:0] data_in;
  logic        evt_out, wr_en;
  logic [31:0] wr_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ilock_acq_ctrl u0 (
    .clk(clk), .rst(rst), .en(en), .trig_pol(trig_pol), .evt_pol(evt_pol),
    .gap_cycles(gap_cycles), .trig_in(trig_in), .data_in(data_in),
    .fifo_space(fifo_space), .evt_out(evt_out), .wr_en(wr_en), .wr_data(wr_data)
  );

  function automatic bit offer();
    return evt_out == evt_pol;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic set_mode(input bit tp, input bit ep);
    @(negedge clk);
    en = 1'b0;
    trig_pol = tp;
    evt_pol = ep;
    trig_in = ~tp;
    repeat (5) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic wait_offer(input bit want, input int lim, output int n);
    n = 0;
    while ((offer() != want) && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic handshake(input logic [31:0] word, input logic [15:0] dly);
    int n;
    bit extra;
    gap_cycles = dly;
    wait_offer(1'b1, 60, n);
    check(offer(), "R2 offer present", offer(), 1);
    data_in = word;
    @(negedge clk);
    trig_in = trig_pol;
    wait_offer(1'b0, 10, n);
    check(!offer(), "R8 offer withdrawn after trigger", offer(), 0);
    repeat (3) @(negedge clk);
    check(!offer(), "R8 offer stays down while trigger held", offer(), 0);
    data_in = ~word;
    trig_in = ~trig_pol;
    n = 0;
    while (!wr_en && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(wr_en && wr_data == word, "R5 captured word", wr_data, word);
    n = 0;
    extra = 0;
    do begin
      @(negedge clk);
      n++;
      if (wr_en) extra = 1;
    end while (!offer() && n < int'(dly) + 10);
    check(!extra, "R6 single strobe", extra, 0);
    check(n == int'(dly) + 1, "R7 gap length", n, int'(dly) + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] w;
    rst = 1'b1; en = 1'b0; trig_pol = 1'b1; evt_pol = 1'b1; trig_in = 1'b0;
    fifo_space = 1'b0; gap_cycles = '0; data_in = '0;
    repeat (4) @(negedge clk);
    check(evt_out == 1'b0 && !wr_en, "R1 reset idle (pol high)", {evt_out, wr_en}, 0);
    evt_pol = 1'b0;
    @(negedge clk); @(negedge clk);
    check(evt_out == 1'b1, "R1 reset idle level follows pol", evt_out, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(evt_out == 1'b1 && !wr_en, "R1 idle after reset with en low", {evt_out, wr_en}, 2);

    // R2: gating by fifo space
    set_mode(1'b1, 1'b1);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (offer()) n++;
    end
    check(n == 0, "R2 no offer without space", n, 0);
    fifo_space = 1'b1;
    @(negedge clk);
    check(offer(), "R2 offer one cycle after space", offer(), 1);
    fifo_space = 1'b0;
    @(negedge clk);
    check(!offer(), "R2 offer withdrawn when space lost", offer(), 0);
    fifo_space = 1'b1;

    // R3 R4 R5 R6 R7 sweep over polarities and gaps
    for (int tp = 0; tp < 2; tp++) begin
      for (int ep = 0; ep < 2; ep++) begin
        set_mode(tp[0], ep[0]);
        for (int k = 0; k < 5; k++) begin
          logic [15:0] d;
          case (k)
            0: d = 16'd0;
            1: d = 16'd1;
            2: d = 16'd2;
            3: d = 16'd5;
            default: d = 16'd13;
          endcase
          w = 32'h5A3C_0000 ^ (32'(tp) << 28) ^ (32'(ep) << 24) ^ (32'(k) * 32'h0001_1111);
          handshake(w, d);
          check(1'b1, "R3 R4 polarity combination exercised", 0, 0);
        end
      end
    end
    set_mode(1'b1, 1'b1);
    handshake(32'hDEAD_BEEF, 16'd300);
    handshake(32'h0000_0001, 16'd0);

    // R9: enable drop withdraws a standing offer
    gap_cycles = 16'd0;
    wait_offer(1'b1, 20, n);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!offer(), "R9 offer dropped on disable", offer(), 0);
    en = 1'b1;

    // R9: enable drop between trigger assert and release discards the word
    wait_offer(1'b1, 20, n);
    data_in = 32'h1234_5678;
    @(negedge clk);
    trig_in = trig_pol;
    wait_offer(1'b0, 10, n);
    en = 1'b0;
    trig_in = ~trig_pol;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wr_en || offer()) n++;
    end
    check(n == 0, "R9 abandoned transfer not written", n, 0);
    en = 1'b1;
    handshake(32'hCAFE_0009, 16'd3);

    // R10: trigger edge and loss of space arrive together
    gap_cycles = 16'd0;
    wait_offer(1'b1, 20, n);
    data_in = 32'h0BAD_F00D;
    @(negedge clk);
    trig_in = trig_pol;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    fifo_space = 1'b0;
    @(negedge clk);
    check(!offer(), "R10 offer down after collision", offer(), 0);
    data_in = 32'h0;
    trig_in = ~trig_pol;
    n = 0;
    while (!wr_en && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(wr_en && wr_data == 32'h0BAD_F00D, "R10 word still written", wr_data, 32'h0BAD_F00D);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (offer()) n++;
    end
    check(n == 0, "R10 no offer while space low", n, 0);
    fifo_space = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(offer(), "R10 offer resumes with space", offer(), 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule